// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Flag Register

This block performs one arithmetic or logical operation on two byte operands in the same cycle and works out the condition flags that the operation produces. A small clocked status register holds those flags. The unit uses that register as the source of the carry-in and of the zero flag that multi-byte operations chain through. Every operation changes only its own set of flags. The block shows which set through a per-operation flag mask. It also presents the merged next status value, so an instruction pipeline can see the outcome before it commits.

The surrounding core chooses an operation code and drives the operands. It raises `exec_i` for one clock to commit the merged status. The core writes the result back to its destination register only when `wr_en_o` is high. The compare operations change flags only. The two top status bits, for interrupt enable and bit copy, belong to other logic. This unit never changes them, and they reset to zero.

Top module: `alu8_core`

## Requirements
- R1: The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, INC=6, DEC=7, AND=8, OR=9, XOR=10, COM=11 and NEG=12. The arithmetic results are a+b, a+b+C, a-b, a-b-C, a+1, a-1 and 0-a, all modulo 256. NEG of 0x80 gives 0x80.
- R2: AND, OR and XOR give the bitwise result of a and b. COM gives the bitwise inverse of a.
- R3: `wr_en_o` is 1 for every defined operation except CP and CPC, which only compute flags.
- R4: `flag_mask_o` has bit 5 (H), bit 4 (S), bit 3 (V), bit 2 (N), bit 1 (Z) and bit 0 (C). It is 0x3F for ADD, ADC, SUB, SBC, CP, CPC and NEG. It is 0x1E for INC, DEC, AND, OR, XOR and COM, so INC and DEC leave C unchanged.
- R5: N is bit 7 of the result. For every operation except SBC and CPC, Z is 1 exactly when the 8-bit result is zero.
- R6: S always equals N XOR V.
- R7: For additions, C is the carry out of bit 7. For subtractions, compares and NEG, C is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow-in. ADC, SBC and CPC take the stored C as carry or borrow in.
- R8: H is the carry from bit 3 into bit 4 for additions. For subtractions, compares and NEG, H is the borrow into bit 3.
- R9: V marks signed overflow of the arithmetic result. It is 1 for INC only when a=0x7F, for DEC only when a=0x80, and for NEG only when a=0x80. The logical operations clear V.
- R10: For SBC and CPC, the new Z is 1 only if the result is zero and the stored Z is already 1.
- R11: The status register has bit order I,T,H,S,V,N,Z,C from bit 7 down to bit 0. It clears on a clock edge with `rst_n` low. On an edge with `exec_i` high it loads `flags_next_o`, which keeps every unmasked bit. With `exec_i` low it holds. I and T never change.
- R12: Codes 13, 14 and 15 are no-ops: the result is 0, `wr_en_o` is 0 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand |
| exec_i | input | 1 | Commit the merged flags to the status register |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flag_mask_o | output | 8 | Flags the current operation changes |
| flags_next_o | output | 8 | Status value after this operation |
| status_o | output | 8 | Current status register |

## Verification
The bench sweeps every operation over all operand pairs from four stored carry and zero states. This catches a carry-in taken from the wrong place. A design with that fault would give the right ADD result and the wrong ADC result. The sweep also covers the overflow corner cases: INC of 0x7F, DEC of 0x80 and NEG of 0x80. If the half-carry used bit 4 instead of bit 3, or the borrow-style carry had inverted polarity, nearly every subtract vector would report a mismatch. Clocked sequences cover two chained cases. A two-byte add must carry into the high byte. An equal two-byte compare must keep Z set, and a difference only in the low byte must clear it. A design that computed Z from the last byte alone would wrongly report equality.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes, flag positions and decode record for the
// byte ALU. Assumes an 8-bit status register ordered I,T,H,S,V,N,Z,C.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_CP    = 4'd4,
        OP_CPC   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_AND   = 4'd8,
        OP_OR    = 4'd9,
        OP_XOR   = 4'd10,
        OP_COM   = 4'd11,
        OP_NEG   = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_COM = 2'd3
    } lg_sel_e;

    localparam int STAT_W = 8;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    localparam logic [STAT_W-1:0] MASK_FULL = 8'b0011_1111;
    localparam logic [STAT_W-1:0] MASK_SVNZ = 8'b0001_1110;
    localparam logic [STAT_W-1:0] MASK_NONE = 8'b0000_0000;

    typedef struct packed {
        logic              arith;    // adder path selected
        logic              logic_en; // bitwise path selected
        logic              sub;      // adder subtracts
        logic              use_cin;  // take stored C as carry/borrow in
        logic              x_zero;   // first adder input forced to zero (negate)
        logic              y_one;    // second adder input forced to one (inc/dec)
        logic              wr;       // destination write enable
        logic              chain_z;  // Z may only be kept or cleared
        lg_sel_e           lsel;     // bitwise function
        logic [STAT_W-1:0] mask;     // flags this operation changes
    } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
// Module: alu8_decode
// Turns an operation code into the control record that steers the datapath
// and the flag merge. Purely combinational; reserved codes decode to a no-op.
module alu8_decode
    import alu8_pkg::*;
(
    input  alu_op_e   op_i,
    output alu_ctrl_t ctrl_o
);

    // Per-operation control record.
    always_comb begin
        ctrl_o = '{arith: 1'b0, logic_en: 1'b0, sub: 1'b0, use_cin: 1'b0,
                   x_zero: 1'b0, y_one: 1'b0, wr: 1'b0, chain_z: 1'b0,
                   lsel: LG_AND, mask: MASK_NONE};
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                ctrl_o.arith   = 1'b1;
                ctrl_o.use_cin = (op_i == OP_ADC);
                ctrl_o.wr      = 1'b1;
                ctrl_o.mask    = MASK_FULL;
            end
            OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
                ctrl_o.arith   = 1'b1;
                ctrl_o.sub     = 1'b1;
                ctrl_o.use_cin = (op_i == OP_SBC) || (op_i == OP_CPC);
                ctrl_o.chain_z = (op_i == OP_SBC) || (op_i == OP_CPC);
                ctrl_o.wr      = (op_i == OP_SUB) || (op_i == OP_SBC);
                ctrl_o.mask    = MASK_FULL;
            end
            OP_INC, OP_DEC: begin
                ctrl_o.arith = 1'b1;
                ctrl_o.sub   = (op_i == OP_DEC);
                ctrl_o.y_one = 1'b1;
                ctrl_o.wr    = 1'b1;
                ctrl_o.mask  = MASK_SVNZ;
            end
            OP_NEG: begin
                ctrl_o.arith  = 1'b1;
                ctrl_o.sub    = 1'b1;
                ctrl_o.x_zero = 1'b1;
                ctrl_o.wr     = 1'b1;
                ctrl_o.mask   = MASK_FULL;
            end
            OP_AND, OP_OR, OP_XOR, OP_COM: begin
                ctrl_o.logic_en = 1'b1;
                ctrl_o.wr       = 1'b1;
                ctrl_o.mask     = MASK_SVNZ;
                ctrl_o.lsel     = lg_sel_e'(op_i[1:0]);
            end
            default: begin
                ctrl_o.mask = MASK_NONE;
            end
        endcase
    end

endmodule

// File: rtl/alu8_addsub.sv
// Module: alu8_addsub
// Shared adder/subtractor with carry or borrow in. Derives carry/borrow,
// half carry/borrow and signed overflow from operand and result sign bits.
// Assumes DATA_W is even and at least 4, so the half point is bit DATA_W/2-1.
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] r_o,
    output logic              c_o,
    output logic              h_o,
    output logic              v_o
);

    localparam int MSB = DATA_W - 1;
    localparam int HB  = DATA_W / 2 - 1;

    logic [DATA_W-1:0] y_eff;
    logic              cin_eff;

    // Two's complement subtraction: invert subtrahend and the borrow.
    always_comb begin
        y_eff   = sub_i ? ~y_i : y_i;
        cin_eff = sub_i ? ~cin_i : cin_i;
        r_o     = x_i + y_eff + {{(DATA_W-1){1'b0}}, cin_eff};
    end

    // Carry, half carry and overflow from the sign-bit equations.
    always_comb begin
        if (!sub_i) begin
            c_o = (x_i[MSB] & y_i[MSB]) | (y_i[MSB] & ~r_o[MSB]) | (~r_o[MSB] & x_i[MSB]);
            h_o = (x_i[HB] & y_i[HB]) | (y_i[HB] & ~r_o[HB]) | (~r_o[HB] & x_i[HB]);
            v_o = (x_i[MSB] & y_i[MSB] & ~r_o[MSB]) | (~x_i[MSB] & ~y_i[MSB] & r_o[MSB]);
        end else begin
            c_o = (~x_i[MSB] & y_i[MSB]) | (y_i[MSB] & r_o[MSB]) | (r_o[MSB] & ~x_i[MSB]);
            h_o = (~x_i[HB] & y_i[HB]) | (y_i[HB] & r_o[HB]) | (r_o[HB] & ~x_i[HB]);
            v_o = (x_i[MSB] & ~y_i[MSB] & ~r_o[MSB]) | (~x_i[MSB] & y_i[MSB] & r_o[MSB]);
        end
    end

endmodule

// File: rtl/alu8_logic.sv
// Module: alu8_logic
// Bitwise unit: AND, OR, XOR of both operands, or inverse of the first.
// Purely combinational, one output bit per input bit pair.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  lg_sel_e           sel_i,
    output logic [DATA_W-1:0] r_o
);

    // Per-bit function selection.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                LG_AND:  r_o[i] = a_i[i] & b_i[i];
                LG_OR:   r_o[i] = a_i[i] | b_i[i];
                LG_XOR:  r_o[i] = a_i[i] ^ b_i[i];
                default: r_o[i] = ~a_i[i];
            endcase
        end
    end

endmodule

// File: rtl/alu8_core.sv
// Module: alu8_core (top)
// Byte ALU with per-operation flag mask and a clocked status register.
// The stored C feeds carry-chained operations, the stored Z feeds chained zero
// tests. I and T are never modified. Synchronous active-low reset.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              exec_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [STAT_W-1:0] flag_mask_o,
    output logic [STAT_W-1:0] flags_next_o,
    output logic [STAT_W-1:0] status_o
);

    localparam int MSB = DATA_W - 1;

    alu_op_e           op_e;
    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] x_in, y_in, ar_res, lg_res;
    logic              ar_c, ar_h, ar_v, cin;
    logic [STAT_W-1:0] status_q, calc;
    logic              n_f, z_raw, z_f, v_f;

    assign op_e = alu_op_e'(op_i);

    alu8_decode u_decode (
        .op_i   (op_e),
        .ctrl_o (ctrl)
    );

    // Adder operand and carry-in selection.
    always_comb begin
        x_in = ctrl.x_zero ? '0 : a_i;
        y_in = ctrl.y_one ? {{(DATA_W-1){1'b0}}, 1'b1} : (ctrl.x_zero ? a_i : b_i);
        cin  = ctrl.use_cin & status_q[FL_C];
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .x_i   (x_in),
        .y_i   (y_in),
        .sub_i (ctrl.sub),
        .cin_i (cin),
        .r_o   (ar_res),
        .c_o   (ar_c),
        .h_o   (ar_h),
        .v_o   (ar_v)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (ctrl.lsel),
        .r_o   (lg_res)
    );

    // Result select and flag computation.
    always_comb begin
        result_o = ctrl.arith ? ar_res : (ctrl.logic_en ? lg_res : '0);
        n_f      = result_o[MSB];
        z_raw    = (result_o == '0);
        z_f      = ctrl.chain_z ? (z_raw & status_q[FL_Z]) : z_raw;
        v_f      = ctrl.arith & ar_v;
        calc     = '0;
        calc[FL_C] = ar_c;
        calc[FL_Z] = z_f;
        calc[FL_N] = n_f;
        calc[FL_V] = v_f;
        calc[FL_S] = n_f ^ v_f;
        calc[FL_H] = ar_h;
    end

    // Masked merge into the next status value.
    always_comb begin
        wr_en_o      = ctrl.wr;
        flag_mask_o  = ctrl.mask;
        flags_next_o = (status_q & ~ctrl.mask) | (calc & ctrl.mask);
    end

    // Status register: clear on reset, load on execute, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= '0;
        else if (exec_i) status_q <= flags_next_o;
    end

    assign status_o = status_q;

    // Assertion arming: set once a reset edge has been seen.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b1;
    end

    p_it_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && exec_i) |=> status_o[FL_I:FL_T] == $past(status_o[FL_I:FL_T]));

    p_unmasked_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && exec_i) |=> ((status_o ^ $past(status_o)) & ~$past(flag_mask_o)) == '0);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !exec_i) |=> $stable(status_o));

    p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CP || op_i == OP_CPC) |-> !wr_en_o);

    p_sign_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_armed |-> status_o[FL_S] == (status_o[FL_N] ^ status_o[FL_V]));

    p_neg_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NEG && a_i == 8'h80) |-> result_o == 8'h80);

    p_chain_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SBC || op_i == OP_CPC) && !status_o[FL_Z]) |-> !flags_next_o[FL_Z]);

    p_inc_keep_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |-> flags_next_o[FL_C] == status_o[FL_C]);

endmodule

// File: tb/alu8_core_tb.sv
// Bench: exhaustive sweep of every operation and operand pair from four
// stored carry/zero states, plus clocked chaining and status sequences.
module alu8_core_tb;
    timeunit 1ns;
    timeprecision 10ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic       exec = 1'b0;
    logic [7:0] result, fmask, fnext, status;
    logic       wr_en;

    int checks = 0;
    int failures = 0;
    logic [7:0] st_exp = '0;
    bit done = 0;

    always #4 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .exec_i(exec),
        .result_o(result), .wr_en_o(wr_en), .flag_mask_o(fmask),
        .flags_next_o(fnext), .status_o(status)
    );

    // Reference computed arithmetically from the requirements.
    task automatic model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] st, output logic [7:0] res, output logic wr,
                         output logic [7:0] msk, output logic [7:0] nxt);
        int ux = x, uy = y, sx = $signed(x), sy = $signed(y);
        int ci, full, sr;
        logic c = 0, h = 0, v = 0, n, z, chain = 0;
        logic [7:0] calc;
        res = 0; wr = 0; msk = 8'h00;
        case (o)
            4'd0, 4'd1: begin
                ci = (o == 4'd1) ? int'(st[0]) : 0;
                full = ux + uy + ci; res = full[7:0]; c = full > 255;
                h = ((ux % 16) + (uy % 16) + ci) > 15;
                sr = sx + sy + ci; v = (sr > 127) || (sr < -128);
                wr = 1; msk = 8'h3F;
            end
            4'd2, 4'd3, 4'd4, 4'd5: begin
                ci = (o == 4'd3 || o == 4'd5) ? int'(st[0]) : 0;
                full = ux - uy - ci; res = full[7:0]; c = ux < uy + ci;
                h = (ux % 16) < (uy % 16) + ci;
                sr = sx - sy - ci; v = (sr > 127) || (sr < -128);
                wr = (o == 4'd2 || o == 4'd3); msk = 8'h3F;
                chain = (o == 4'd3 || o == 4'd5);
            end
            4'd6: begin full = ux + 1; res = full[7:0]; v = (sx + 1) > 127; wr = 1; msk = 8'h1E; end
            4'd7: begin full = ux - 1; res = full[7:0]; v = (sx - 1) < -128; wr = 1; msk = 8'h1E; end
            4'd8:  begin res = x & y; wr = 1; msk = 8'h1E; end
            4'd9:  begin res = x | y; wr = 1; msk = 8'h1E; end
            4'd10: begin res = x ^ y; wr = 1; msk = 8'h1E; end
            4'd11: begin res = ~x;    wr = 1; msk = 8'h1E; end
            4'd12: begin
                full = 0 - ux; res = full[7:0]; c = 0 < ux; h = 0 < (ux % 16);
                v = (0 - sx) > 127; wr = 1; msk = 8'h3F;
            end
            default: begin res = 0; wr = 0; msk = 8'h00; end
        endcase
        n = res[7];
        z = (res == 8'h00) && (chain ? st[1] : 1'b1);
        calc = {2'b00, h, n ^ v, v, n, z, c};
        nxt = (st & ~msk) | (calc & msk);
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, op, a, b, act, exp);
        end
    endtask

    function automatic string flag_tag(input logic [3:0] o, input logic [7:0] d);
        if (o >= 4'd13)                            return "R12";
        if (d[1] && (o == 4'd3 || o == 4'd5))      return "R10";
        if (d[4])                                  return "R6";
        if (d[0])                                  return "R7";
        if (d[5])                                  return "R8";
        if (d[3])                                  return "R9";
        if (d[2] || d[1])                          return "R5";
        return "R11";
    endfunction

    // Combinational check of all outputs for the present inputs.
    task automatic check_now();
        logic [7:0] er, em, en;
        logic ew;
        model(op, a, b, status, er, ew, em, en);
        check(op >= 4'd13 ? "R12" : (op >= 4'd8 && op <= 4'd11) ? "R2" : "R1", "result", result, er);
        check(op >= 4'd13 ? "R12" : "R3", "wr_en", wr_en, ew);
        check(op >= 4'd13 ? "R12" : "R4", "mask", fmask, em);
        check(flag_tag(op, fnext ^ en), "flags_next", fnext, en);
    endtask

    // Commit one operation and check the stored status.
    task automatic do_exec(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                           input string tag);
        logic [7:0] er, em, en;
        logic ew;
        op = o; a = x; b = y; exec = 1'b1;
        model(o, x, y, st_exp, er, ew, em, en);
        @(posedge clk); #2;
        exec = 1'b0;
        st_exp = en;
        check(tag, "status", status, st_exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R11", "reset status", status, 8'h00);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R11", "status after release", status, 8'h00);

        // Sweep every op and operand pair from four stored C/Z states (R7, R10).
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: do_exec(4'd0, 8'h01, 8'h01, "R11"); // C=0 Z=0
                1: do_exec(4'd0, 8'h00, 8'h00, "R11"); // C=0 Z=1
                2: do_exec(4'd0, 8'hFF, 8'h02, "R11"); // C=1 Z=0
                default: do_exec(4'd0, 8'h80, 8'h80, "R11"); // C=1 Z=1
            endcase
            check("R7", "preset C", status[0], s / 2);
            check("R5", "preset Z", status[1], s % 2);
            for (int o = 0; o < 16; o++) begin
                for (int x = 0; x < 256; x++) begin
                    for (int y = 0; y < 256; y++) begin
                        op = o[3:0]; a = x[7:0]; b = y[7:0];
                        #0.1;
                        check_now();
                    end
                end
            end
        end

        // Two-byte add 0x12FF + 0x0001 = 0x1300 (R7).
        do_exec(4'd0, 8'hFF, 8'h01, "R7");
        check("R7", "low byte carry", status[0], 1);
        op = 4'd1; a = 8'h12; b = 8'h00; #1;
        check("R7", "high byte with carry", result, 8'h13);
        do_exec(4'd1, 8'h12, 8'h00, "R7");

        // Equal two-byte compare keeps Z (R10).
        do_exec(4'd4, 8'h00, 8'h00, "R10");
        do_exec(4'd5, 8'h34, 8'h34, "R10");
        check("R10", "equal pair Z", status[1], 1);
        // Low bytes differ, high bytes equal: Z must end clear (R10).
        do_exec(4'd4, 8'h01, 8'h00, "R10");
        do_exec(4'd5, 8'h34, 8'h34, "R10");
        check("R10", "unequal pair Z", status[1], 0);

        // Idle clock must not load flags (R11).
        op = 4'd0; a = 8'h80; b = 8'h80; exec = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        check("R11", "hold without exec", status, st_exp);

        // INC/DEC keep C: set C, then INC 0xFF (R4, R9).
        do_exec(4'd0, 8'hFF, 8'h01, "R4");
        do_exec(4'd6, 8'hFF, 8'h00, "R4");
        check("R4", "inc keeps C", status[0], 1);
        do_exec(4'd6, 8'h7F, 8'h00, "R9");
        check("R9", "inc 7F overflow", status[3], 1);
        do_exec(4'd12, 8'h80, 8'h00, "R9");
        check("R9", "neg 80 overflow", status[3], 1);
        check("R11", "I/T untouched", status[7:6], 0);

        // Reset clears a populated status (R11).
        rst_n = 1'b0;
        @(posedge clk); #2;
        check("R11", "reset clears", status, 8'h00);
        rst_n = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500us;
        if (!done) begin
            failures++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule